// File: doc/BRIEF.md
# Faulted-Channel Identification Sequencer

This block runs on the controller side of a two-channel high-side switch whose channels share one active-low fault line. When that line asserts, or when software issues a start pulse, the sequencer works out which channel raised the fault and what kind of fault it is, without disturbing either load. It owns the two enable lines and the select line of the switch. While idle it passes the requested enable levels straight through, and it only takes control of the lines for the length of one search.

It has two search methods. In the toggle method each enable is inverted in turn for a short, fixed number of cycles. The pulse is kept well below the ten-microsecond limit that the loads tolerate. After each pulse the sequencer waits a settle time and then looks at the shared fault line. A fault line that clears points at the channel just pulsed. A fault line that survives both pulses points at both channels. In the sense method the select line is stepped low and then high, and a synchronized "sense at fault level" input is sampled after each step.

Each channel's fault is then classed by the enable level it had when the search began. An enabled channel points to overcurrent or overtemperature; a disabled channel points to open load or a short to supply. The search ends with a one-cycle done strobe, and the enables go back to the requested levels.

Top module: `fault_locator`

## Requirements
- R1: While rst_n is low, busy_o, done_o, sel_o, fault_mask_o and fault_onstate_o are 0, and en_o equals en_req_i.
- R2: While busy_o is low, en_o follows en_req_i in the same cycle and sel_o is 0.
- R3: While idle, a search starts on a high start_i sampled at a clock edge, or on the high-to-low transition of flt_n_i after a SYNC_STAGES-flop synchronizer. busy_o is high from the next cycle through the done cycle.
- R4: Toggle method (use_sense_i = 0 when the search starts): each identification pulse inverts exactly one enable for exactly PULSE_CYC cycles. Channel 0 (bit 0) is pulsed before channel 1 (bit 1). The other enable stays at its level from the start of the search.
- R5: After each pulse and a SETTLE_CYC wait, the synchronized fault line is sampled. If it is clear after the channel 0 pulse, the mask is 2'b01 and channel 1 is not pulsed. If it is clear only after the channel 1 pulse, the mask is 2'b10. If it persists after both pulses, the mask is 2'b11.
- R6: Toggle method: the fault line is first sampled SETTLE_CYC cycles after the start. If no fault is present then, the search ends with mask 2'b00 and no enable pulse.
- R7: Sense method (use_sense_i = 1 when the search starts): sel_o is 0 for SETTLE_CYC cycles and then 1 for SETTLE_CYC cycles. sns_flag_i is sampled at the end of each step to set mask bit 0 (select low) and mask bit 1 (select high). No enable pulse is issued.
- R8: fault_onstate_o equals fault_mask_o AND the enable levels captured at the start. A 1 means on-state class (overcurrent or overtemperature). A faulted bit at 0 means off-state class (open load or short to supply).
- R9: done_o is high for exactly one cycle per search. During that cycle en_o equals the levels captured at the start, and fault_mask_o and fault_onstate_o hold their new values. The result outputs change at no other time.
- R10: While busy_o is high, changes on en_req_i, use_sense_i and start_i, and new fault transitions, neither alter the running search nor start another.
- R11: PULSE_CYC clock periods at CLK_KHZ must come to less than 10000 ns; this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_n_i | input | 1 | Shared fault line from the switch, active low, asynchronous |
| sns_flag_i | input | 1 | High when the sense output shows the fault level, asynchronous |
| start_i | input | 1 | Single-cycle request to search without a fault edge |
| use_sense_i | input | 1 | 0 selects the toggle method, 1 the sense method |
| en_req_i | input | 2 | Requested enable levels, bit 0 for channel 0 |
| en_o | output | 2 | Enable lines driven to the switch |
| sel_o | output | 1 | Sense select line, 0 for channel 0 |
| busy_o | output | 1 | High while a search runs |
| done_o | output | 1 | One-cycle strobe at the end of a search |
| fault_mask_o | output | 2 | Faulted channels found by the last search |
| fault_onstate_o | output | 2 | Per channel: 1 on-state class, 0 off-state class |

## Verification
Some properties are checked on every cycle. Each pulse must have the exact programmed width, and no more than one enable may differ from the captured levels at any time. The select line may never rise while an enable is inverted. The done strobe must last one cycle, with the enables restored, and it must fall only inside a busy window. The captured levels must stay frozen during a search, and the results may not move except at done. Only the directed scenarios can show the verdict logic itself: which mask follows from which pattern of clearing and persisting faults, the empty result when no fault is present, the class outcome for mixed enable levels, and the fact that inputs changed mid-search are ignored.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHK,
    ST_PULSE,
    ST_RECOVER,
    ST_SELWAIT,
    ST_FINISH
  } fl_state_e;

  // One-hot channel bit for a channel index.
  function automatic logic [1:0] fl_chan_bit(input logic ch);
    return ch ? 2'b10 : 2'b01;
  endfunction

  // On-state class: faulted and enabled when the search began.
  function automatic logic [1:0] fl_class_on(input logic [1:0] mask,
                                             input logic [1:0] en_cap);
    return mask & en_cap;
  endfunction

  // Verdict after a pulse on channel ch.
  function automatic logic [1:0] fl_toggle_verdict(input logic ch,
                                                   input logic still_faulted);
    if (!still_faulted) return fl_chan_bit(ch);
    return ch ? 2'b11 : 2'b00;
  endfunction

  // Pulse length in ns for a cycle count at a clock in kHz.
  function automatic longint fl_cycles_to_ns(input longint cyc,
                                             input longint khz);
    return (cyc * 64'd1000000) / khz;
  endfunction

endpackage

// File: rtl/fl_sync.sv
module fl_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i - TW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  // A zero-length window would wrap the counter and stretch a pulse (R4).
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> load_val_i != '0);

  // Expiry ends the window unless it is reloaded (R4).
  p_expire_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !load_i |=> !expired_o);

endmodule

// File: rtl/fl_seq.sv
module fl_seq
  import fl_pkg::*;
#(
  parameter int TW         = 6,
  parameter int PULSE_CYC  = 40,
  parameter int SETTLE_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          use_sense_i,
  input  logic [1:0]    en_req_i,
  input  logic          fault_now_i,
  input  logic          sns_now_i,
  input  logic          tmr_exp_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic [1:0]    en_o,
  output logic          sel_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    mask_o,
  output logic [1:0]    onstate_o,
  output logic [1:0]    en_snap_o
);

  localparam logic [TW-1:0] PULSE_V  = TW'(PULSE_CYC);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC);

  fl_state_e  state_q, state_d;
  logic       ch_q, ch_d;
  logic [1:0] work_q, work_d;
  logic [1:0] snap_q;
  logic [1:0] mask_q, on_q;

  // Named events for the assertions.
  logic       accept_evt;
  logic       finish_evt;
  logic [1:0] pulse_flip;

  assign accept_evt = (state_q == ST_IDLE) && trig_i;
  assign finish_evt = (state_d == ST_FINISH) && (state_q != ST_FINISH);
  assign pulse_flip = (state_q == ST_PULSE) ? fl_chan_bit(ch_q) : 2'b00;

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    work_d     = work_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = SETTLE_V;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          ch_d       = 1'b0;
          work_d     = 2'b00;
          tmr_load_o = 1'b1;
          state_d    = use_sense_i ? ST_SELWAIT : ST_PRECHK;
        end
      end
      ST_PRECHK: begin
        if (tmr_exp_i) begin
          if (fault_now_i) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = PULSE_V;
            state_d    = ST_PULSE;
          end else begin
            work_d  = 2'b00;
            state_d = ST_FINISH;
          end
        end
      end
      ST_PULSE: begin
        if (tmr_exp_i) begin
          tmr_load_o = 1'b1;
          state_d    = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (tmr_exp_i) begin
          if (fault_now_i && !ch_q) begin
            ch_d       = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = PULSE_V;
            state_d    = ST_PULSE;
          end else begin
            work_d  = fl_toggle_verdict(ch_q, fault_now_i);
            state_d = ST_FINISH;
          end
        end
      end
      ST_SELWAIT: begin
        if (tmr_exp_i) begin
          work_d = work_q | (sns_now_i ? fl_chan_bit(ch_q) : 2'b00);
          if (!ch_q) begin
            ch_d       = 1'b1;
            tmr_load_o = 1'b1;
          end else begin
            state_d = ST_FINISH;
          end
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= 1'b0;
      work_q  <= 2'b00;
      snap_q  <= 2'b00;
      mask_q  <= 2'b00;
      on_q    <= 2'b00;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      work_q  <= work_d;
      if (accept_evt) snap_q <= en_req_i;
      if (finish_evt) begin
        mask_q <= work_d;
        on_q   <= fl_class_on(work_d, snap_q);
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FINISH);
  assign sel_o     = (state_q == ST_SELWAIT) && ch_q;
  assign en_o      = busy_o ? (snap_q ^ pulse_flip) : en_req_i;
  assign mask_o    = mask_q;
  assign onstate_o = on_q;
  assign en_snap_o = snap_q;

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_done_restored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> en_o == snap_q);

  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mask_o) && $stable(onstate_o));

  p_class_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (onstate_o & ~mask_o) == 2'b00);

  p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $countones(en_o ^ snap_q) <= 1);

  p_sel_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> en_o == snap_q);

  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> $stable(snap_q) && busy_o);

endmodule

// File: rtl/fault_locator.sv
module fault_locator
  import fl_pkg::*;
#(
  parameter int CLK_KHZ      = 125000,
  parameter int MAX_PULSE_NS = 10000,
  parameter int PULSE_CYC    = 40,
  parameter int SETTLE_CYC   = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flt_n_i,
  input  logic       sns_flag_i,
  input  logic       start_i,
  input  logic       use_sense_i,
  input  logic [1:0] en_req_i,
  output logic [1:0] en_o,
  output logic       sel_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] fault_mask_o,
  output logic [1:0] fault_onstate_o
);

  localparam int     MAX_WIN  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int     TW       = $clog2(MAX_WIN + 1);
  localparam longint PULSE_NS = fl_cycles_to_ns(PULSE_CYC, CLK_KHZ);

  initial begin
    p_pulse_bound_r11: assert (PULSE_NS < MAX_PULSE_NS && PULSE_CYC > 0 && SETTLE_CYC > 0)
      else $error("identification pulse of %0d ns breaks the %0d ns bound", PULSE_NS, MAX_PULSE_NS);
  end

  // Bit 1: fault line (idles high), bit 0: sense flag (idles low).
  logic [1:0] sync_q;
  logic       flt_n_s, sns_s, flt_n_d;
  logic       fault_evt, trig;

  fl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({flt_n_i, sns_flag_i}),
    .q_o   (sync_q)
  );

  assign flt_n_s = sync_q[1];
  assign sns_s   = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_n_d <= 1'b1;
    else        flt_n_d <= flt_n_s;
  end

  assign fault_evt = flt_n_d && !flt_n_s;
  assign trig      = start_i || fault_evt;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic [1:0]    en_snap;

  fl_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  fl_seq #(.TW(TW), .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .use_sense_i (use_sense_i),
    .en_req_i    (en_req_i),
    .fault_now_i (!flt_n_s),
    .sns_now_i   (sns_s),
    .tmr_exp_i   (tmr_exp),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .en_o        (en_o),
    .sel_o       (sel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mask_o      (fault_mask_o),
    .onstate_o   (fault_onstate_o),
    .en_snap_o   (en_snap)
  );

  // Pulse width watch: a counter instead of a long $past window.
  logic          pulse_on;
  logic [TW:0]   pw_cnt;

  assign pulse_on = busy_o && (en_o != en_snap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pw_cnt <= '0;
    else if (pulse_on) pw_cnt <= pw_cnt + (TW+1)'(1);
    else               pw_cnt <= '0;
  end

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_on) |-> pw_cnt == (TW+1)'(PULSE_CYC));

  p_pulse_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> pw_cnt < (TW+1)'(PULSE_CYC));

endmodule

// File: tb/fault_locator_tb.sv
module fault_locator_tb;

  localparam int PULSE  = 40;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       start = 1'b0;
  logic       use_sense = 1'b0;
  logic [1:0] en_req = 2'b11;
  logic       flt_n, sns;
  logic [1:0] en_o, mask, onst;
  logic       sel, busy, done;

  fault_locator #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .flt_n_i(flt_n), .sns_flag_i(sns),
    .start_i(start), .use_sense_i(use_sense), .en_req_i(en_req),
    .en_o(en_o), .sel_o(sel), .busy_o(busy), .done_o(done),
    .fault_mask_o(mask), .fault_onstate_o(onst)
  );

  // Switch model: a fault clears on any enable edge of its channel unless it persists.
  logic [1:0] armed = 2'b00, persist = 2'b00;
  int base0 = 0, base1 = 0;
  int tog0, tog1;
  logic [1:0] en_prev;
  logic f0, f1;

  always @(posedge clk) begin
    if (!rst_n) begin
      tog0 <= 0; tog1 <= 0; en_prev <= en_o;
    end else begin
      en_prev <= en_o;
      if (en_o[0] != en_prev[0]) tog0 <= tog0 + 1;
      if (en_o[1] != en_prev[1]) tog1 <= tog1 + 1;
    end
  end

  assign f0    = armed[0] & (persist[0] | (tog0 == base0));
  assign f1    = armed[1] & (persist[1] | (tog1 == base1));
  assign flt_n = ~(f0 | f1);
  assign sns   = sel ? f1 : f0;

  // Port monitor, sampled away from the active edge.
  int run = 0, last_len = 0, npulse = 0, ndone = 0, sel_hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_o != en_req) run++;
      else if (run > 0) begin last_len = run; npulse++; run = 0; end
      if (done) ndone++;
      if (sel) sel_hi++;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; return; end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "done in reset", 32'(done), 0);
    chk("R1", "sel in reset", 32'(sel), 0);
    chk("R1", "mask in reset", 32'(mask), 0);
    chk("R1", "class in reset", 32'(onst), 0);
    chk("R1", "enables in reset", 32'(en_o), 32'(en_req));
    step(); rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic t_idle_pass();
    step(); en_req = 2'b10;
    @(negedge clk);
    chk("R2", "idle enables follow request", 32'(en_o), 32'h2);
    chk("R2", "idle select low", 32'(sel), 0);
    step(); en_req = 2'b11;
    @(negedge clk);
    chk("R2", "idle enables follow request again", 32'(en_o), 32'h3);
  endtask

  // Toggle method with a fault pattern; checks its own verdict.
  task automatic t_toggle(input string tag, input logic [1:0] en,
                          input logic [1:0] arm, input logic [1:0] pers,
                          input logic [1:0] exp_mask, input logic [1:0] exp_on,
                          input int exp_pulses);
    bit ok;
    int np0, nd0;
    step(); en_req = en; use_sense = 1'b0;
    repeat (3) step();
    np0 = npulse; nd0 = ndone;
    base0 = tog0; base1 = tog1; persist = pers; armed = arm;
    wait_done(ok);
    chk("R3", {tag, " search finished"}, 32'(ok), 1);
    chk("R3", {tag, " busy at done"}, 32'(busy), 1);
    chk("R5", {tag, " fault mask"}, 32'(mask), 32'(exp_mask));
    chk("R8", {tag, " class"}, 32'(onst), 32'(exp_on));
    chk("R9", {tag, " enables restored at done"}, 32'(en_o), 32'(en));
    @(negedge clk);
    chk("R9", {tag, " busy low after done"}, 32'(busy), 0);
    step(); armed = 2'b00;
    repeat (SETTLE + 8) step();
    chk("R4", {tag, " pulse count"}, 32'(npulse - np0), 32'(exp_pulses));
    if (exp_pulses > 0) begin
      chk("R4", {tag, " pulse width"}, 32'(last_len), 32'(PULSE));
      chk("R11", {tag, " pulse under 10 us"}, 32'(last_len * 8 < 10000), 1);
    end
    chk("R9", {tag, " one done strobe"}, 32'(ndone - nd0), 1);
  endtask

  task automatic t_nofault_start();
    bit ok;
    int np0;
    step(); en_req = 2'b11; use_sense = 1'b0; armed = 2'b00;
    np0 = npulse;
    start = 1'b1; step(); start = 1'b0;
    wait_done(ok);
    chk("R3", "start pulse launches search", 32'(ok), 1);
    chk("R6", "no fault gives empty mask", 32'(mask), 0);
    chk("R6", "no fault gives empty class", 32'(onst), 0);
    repeat (SETTLE + 4) step();
    chk("R6", "no pulse without fault", 32'(npulse - np0), 0);
  endtask

  task automatic t_sense(input string tag, input logic [1:0] arm,
                         input logic use_start, input logic [1:0] exp_mask,
                         input logic [1:0] exp_on);
    bit ok;
    int np0, sh0;
    step(); en_req = 2'b01; use_sense = 1'b1;
    repeat (3) step();
    np0 = npulse; sh0 = sel_hi;
    base0 = tog0; base1 = tog1; persist = 2'b11; armed = arm;
    if (use_start) begin start = 1'b1; step(); start = 1'b0; end
    wait_done(ok);
    chk("R7", {tag, " search finished"}, 32'(ok), 1);
    chk("R7", {tag, " mask from sense"}, 32'(mask), 32'(exp_mask));
    chk("R8", {tag, " class"}, 32'(onst), 32'(exp_on));
    step(); armed = 2'b00; use_sense = 1'b0;
    repeat (SETTLE + 4) step();
    chk("R7", {tag, " select high window"}, 32'(sel_hi - sh0), 32'(SETTLE));
    chk("R7", {tag, " no enable pulse"}, 32'(npulse - np0), 0);
  endtask

  task automatic t_ignore_busy();
    bit ok;
    int nd0, guard;
    step(); en_req = 2'b11; use_sense = 1'b0;
    repeat (3) step();
    nd0 = ndone;
    base0 = tog0; base1 = tog1; persist = 2'b00; armed = 2'b10;
    guard = 0;
    while (!busy && guard < 100) begin @(negedge clk); guard++; end
    repeat (3) step();
    en_req = 2'b00; use_sense = 1'b1; start = 1'b1;
    step(); start = 1'b0;
    wait_done(ok);
    chk("R10", "search finished", 32'(ok), 1);
    chk("R10", "mask unaffected by mid-search inputs", 32'(mask), 32'h2);
    chk("R10", "class uses levels at start", 32'(onst), 32'h2);
    chk("R10", "enables held at captured levels", 32'(en_o), 32'h3);
    @(negedge clk);
    chk("R2", "enables follow new request after done", 32'(en_o), 32'h0);
    step(); armed = 2'b00; use_sense = 1'b0;
    repeat (30) step();
    chk("R10", "no second search", 32'(ndone - nd0), 1);
    chk("R10", "idle after ignored start", 32'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R3: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_idle_pass();
    t_toggle("ch0 only",        2'b11, 2'b01, 2'b00, 2'b01, 2'b01, 1);
    t_toggle("ch1 only",        2'b11, 2'b10, 2'b00, 2'b10, 2'b10, 2);
    t_toggle("both persistent", 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2);
    t_toggle("ch1 disabled",    2'b01, 2'b10, 2'b00, 2'b10, 2'b00, 2);
    t_toggle("mixed both",      2'b10, 2'b11, 2'b11, 2'b11, 2'b10, 2);
    t_nofault_start();
    t_sense("sense ch0",  2'b01, 1'b0, 2'b01, 2'b01);
    t_sense("sense ch1",  2'b10, 1'b0, 2'b10, 2'b00);
    t_sense("sense both", 2'b11, 1'b0, 2'b11, 2'b01);
    t_sense("sense none", 2'b00, 1'b1, 2'b00, 2'b00);
    t_ignore_busy();
    summary();
    $finish;
  end

endmodule